// File: doc/BRIEF.md
# Receive Address Filter and Error-Bit Policy

This block sits behind the bit-level receiver of a single-wire control bus. For each frame it decodes the destination nibble of the first byte (the header) against a one-hot mask of owned logical addresses. It then decides whether every byte of the frame is stored and whether an acknowledge is driven for it. When the receiver reports a timing error, the block decides whether an error bit goes onto the bus and whether reception is abandoned. It also keeps one sticky flag per error class.

Bytes arrive as single-cycle valid strobes with no back-pressure, because the bus cannot be stalled; there is no ready signal. The first strobed byte after reset, after a byte marked last, or after an abandoned frame is a header. All four decision outputs are registered and pulse exactly one cycle after the strobe or error pulse that caused them. The destination address is taken from header bits 3:0, and the initiator address in bits 7:4 plays no part in the decisions.

Top module: `rxaddr_policy`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, accept, ack_en, errbit_req, rx_stop and err_sticky are all 0.
- R2: A header addresses this device when own_mask bit n is set and the destination (header bits 3:0) equals n, for n from 0 to 14. Several mask bits may be set together, and header bits 7:4 never change any decision.
- R3: With cfg_full_listen low, accept pulses one cycle after every byte of a frame to an owned address or to the broadcast address 0xF. It stays low for every byte of a frame to any other address.
- R4: With cfg_full_listen high, frames to other addresses are also accepted on every byte, but ack_en stays low for them. The listen mode is sampled at the header.
- R5: ack_en pulses one cycle after every byte of a frame to an owned address, and never for a broadcast or foreign frame.
- R6: A byte strobed with rx_last ends the frame, and the next strobed byte is decoded as a header. A header strobed with rx_last is a complete one-byte frame.
- R7: A bit-rising error with cfg_bre_stop high pulses rx_stop one cycle later and abandons the frame. A byte strobed in that same cycle is neither accepted nor acknowledged, and the next byte is a header. With cfg_bre_stop low, a bit-rising error never stops reception.
- R8: Outside a broadcast frame, errbit_req pulses one cycle after an error as follows: for a bit-rising error when cfg_bre_stop and cfg_bre_ebit are both high, for a long-bit-period error when cfg_lbpe_ebit is high, and for a short-bit-period error always. Without an error pulse, errbit_req stays low.
- R9: Inside a broadcast frame with cfg_bcast_quiet low, errbit_req pulses for a bit-rising error when cfg_bre_stop is high, and for a long-bit-period error regardless of cfg_lbpe_ebit. For a short-bit-period error it pulses only while cfg_full_listen is low.
- R10: Inside a broadcast frame with cfg_bcast_quiet high, no error bit is requested for any error. The stop decision of R7 still applies.
- R11: err_sticky bit 0 (bit-rising), bit 1 (short-bit-period) and bit 2 (long-bit-period) are set one cycle after the matching error pulse. They hold until a 1 is written to the same bit of sticky_clr, and a set in the same cycle as a clear leaves the bit at 1.
- R12: The broadcast context applies to errors from the cycle after the header strobe through the cycle of the last-byte strobe. An error in the header strobe cycle, or after the frame has ended, follows R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is on rx_byte |
| rx_byte | input | DATA_W | Received byte; destination in bits 3:0 of a header |
| rx_last | input | 1 | Marks the strobed byte as the last of its frame |
| err_bre | input | 1 | Bit-rising error pulse from the receiver |
| err_sbpe | input | 1 | Short-bit-period error pulse |
| err_lbpe | input | 1 | Long-bit-period error pulse |
| cfg_full_listen | input | 1 | 1: also receive frames to other addresses, without acknowledge |
| cfg_bre_stop | input | 1 | 1: a bit-rising error abandons reception |
| cfg_bre_ebit | input | 1 | Error-bit enable for bit-rising errors |
| cfg_lbpe_ebit | input | 1 | Error-bit enable for long-bit-period errors |
| cfg_bcast_quiet | input | 1 | 1: never drive an error bit in a broadcast frame |
| own_mask | input | 2**ADDR_W-1 | One-hot set of owned logical addresses |
| sticky_clr | input | 3 | Write-1-to-clear for err_sticky |
| accept | output | 1 | Store pulse for the byte strobed in the previous cycle |
| ack_en | output | 1 | Drive acknowledge for the byte strobed in the previous cycle |
| errbit_req | output | 1 | Request an error bit on the bus |
| rx_stop | output | 1 | Reception abandoned |
| err_sticky | output | 3 | Sticky error flags |

## Verification
The collision of interest is a bit-rising error in the same cycle as a byte strobe. Reception stop and byte acceptance then compete for that byte. The bench provokes it inside an owned frame with cfg_bre_stop high and expects rx_stop high with accept and ack_en low. It also expects the following byte to be decoded as a new header, which is visible because that header is then rejected by address. A second same-cycle case drives an error pulse together with the write-1-clear of the same sticky bit and expects the bit to stay set. The reference model checks both cases on every clock.

// File: rtl/rxp_pkg.sv
package rxp_pkg;

  localparam int unsigned NUM_ERR = 3;

  // Error class positions, shared by error vectors and sticky flags.
  localparam int unsigned ERR_BRE  = 0;
  localparam int unsigned ERR_SBPE = 1;
  localparam int unsigned ERR_LBPE = 2;

  typedef struct packed {
    logic full_listen;
    logic bre_stop;
    logic bre_ebit;
    logic lbpe_ebit;
    logic bcast_quiet;
  } policy_cfg_t;

endpackage

// File: rtl/rxp_hdr_filter.sv
module rxp_hdr_filter #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rx_valid,
  input  logic [ADDR_W-1:0]          rx_dest,
  input  logic                       rx_last,
  input  logic                       abort,
  input  logic                       full_listen,
  input  logic [(1<<ADDR_W)-2:0]     own_mask,
  output logic                       accept,
  output logic                       ack_en,
  output logic                       frame_bcast
);

  localparam int unsigned SLOTS = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] BCAST = {ADDR_W{1'b1}};

  logic [SLOTS-1:0] mask_ext;
  logic hdr_bcast, hdr_owned, hdr_keep;
  logic in_frame, ctx_bcast, ctx_owned, ctx_keep;
  logic accept_q, ack_q;

  // The broadcast slot never counts as owned.
  assign mask_ext = {1'b0, own_mask};

  always_comb begin
    hdr_bcast = (rx_dest == BCAST);
    hdr_owned = !hdr_bcast && mask_ext[rx_dest];
    hdr_keep  = hdr_owned || hdr_bcast || full_listen;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame  <= 1'b0;
      ctx_bcast <= 1'b0;
      ctx_owned <= 1'b0;
      ctx_keep  <= 1'b0;
      accept_q  <= 1'b0;
      ack_q     <= 1'b0;
    end else begin
      accept_q <= 1'b0;
      ack_q    <= 1'b0;
      if (abort) begin
        in_frame <= 1'b0;
      end else if (rx_valid) begin
        if (!in_frame) begin
          ctx_bcast <= hdr_bcast;
          ctx_owned <= hdr_owned;
          ctx_keep  <= hdr_keep;
          accept_q  <= hdr_keep;
          ack_q     <= hdr_owned;
        end else begin
          accept_q  <= ctx_keep;
          ack_q     <= ctx_owned;
        end
        in_frame <= !rx_last;
      end
    end
  end

  assign accept      = accept_q;
  assign ack_en      = ack_q;
  assign frame_bcast = in_frame && ctx_bcast;

endmodule

// File: rtl/rxp_err_policy.sv
module rxp_err_policy
  import rxp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  policy_cfg_t        cfg,
  input  logic [NUM_ERR-1:0] err_vec,
  input  logic               bcast_ctx,
  output logic               stop_now,
  output logic               errbit_req,
  output logic               rx_stop
);

  logic [NUM_ERR-1:0] fire;
  logic errbit_q, stop_q;

  for (genvar i = 0; i < NUM_ERR; i++) begin : g_rule
    if (i == ERR_BRE) begin : g_bre
      assign fire[i] = err_vec[i] && cfg.bre_stop &&
                       (bcast_ctx ? !cfg.bcast_quiet : cfg.bre_ebit);
    end else if (i == ERR_LBPE) begin : g_lbpe
      assign fire[i] = err_vec[i] &&
                       (bcast_ctx ? !cfg.bcast_quiet : cfg.lbpe_ebit);
    end else begin : g_sbpe
      assign fire[i] = err_vec[i] &&
                       (bcast_ctx ? (!cfg.bcast_quiet && !cfg.full_listen) : 1'b1);
    end
  end

  assign stop_now = err_vec[ERR_BRE] && cfg.bre_stop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      errbit_q <= 1'b0;
      stop_q   <= 1'b0;
    end else begin
      errbit_q <= |fire;
      stop_q   <= stop_now;
    end
  end

  assign errbit_req = errbit_q;
  assign rx_stop    = stop_q;

endmodule

// File: rtl/rxp_err_sticky.sv
module rxp_err_sticky #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] sticky
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk) begin
      if (!rst_n)          flag_q <= 1'b0;
      else if (set_vec[i]) flag_q <= 1'b1;
      else if (clr_vec[i]) flag_q <= 1'b0;
    end
    assign sticky[i] = flag_q;
  end

endmodule

// File: rtl/rxaddr_policy.sv
module rxaddr_policy #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rx_valid,
  input  logic [DATA_W-1:0]            rx_byte,
  input  logic                         rx_last,
  input  logic                         err_bre,
  input  logic                         err_sbpe,
  input  logic                         err_lbpe,
  input  logic                         cfg_full_listen,
  input  logic                         cfg_bre_stop,
  input  logic                         cfg_bre_ebit,
  input  logic                         cfg_lbpe_ebit,
  input  logic                         cfg_bcast_quiet,
  input  logic [(1<<ADDR_W)-2:0]       own_mask,
  input  logic [rxp_pkg::NUM_ERR-1:0]  sticky_clr,
  output logic                         accept,
  output logic                         ack_en,
  output logic                         errbit_req,
  output logic                         rx_stop,
  output logic [rxp_pkg::NUM_ERR-1:0]  err_sticky
);

  import rxp_pkg::*;

  policy_cfg_t        cfg;
  logic [NUM_ERR-1:0] err_vec;
  logic               stop_now;
  logic               bcast_ctx;

  always_comb begin
    cfg.full_listen = cfg_full_listen;
    cfg.bre_stop    = cfg_bre_stop;
    cfg.bre_ebit    = cfg_bre_ebit;
    cfg.lbpe_ebit   = cfg_lbpe_ebit;
    cfg.bcast_quiet = cfg_bcast_quiet;
    err_vec           = '0;
    err_vec[ERR_BRE]  = err_bre;
    err_vec[ERR_SBPE] = err_sbpe;
    err_vec[ERR_LBPE] = err_lbpe;
  end

  rxp_hdr_filter #(.ADDR_W(ADDR_W)) u_filter (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid    (rx_valid),
    .rx_dest     (rx_byte[ADDR_W-1:0]),
    .rx_last     (rx_last),
    .abort       (stop_now),
    .full_listen (cfg_full_listen),
    .own_mask    (own_mask),
    .accept      (accept),
    .ack_en      (ack_en),
    .frame_bcast (bcast_ctx)
  );

  rxp_err_policy u_policy (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg        (cfg),
    .err_vec    (err_vec),
    .bcast_ctx  (bcast_ctx),
    .stop_now   (stop_now),
    .errbit_req (errbit_req),
    .rx_stop    (rx_stop)
  );

  rxp_err_sticky #(.N(NUM_ERR)) u_sticky (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (err_vec),
    .clr_vec (sticky_clr),
    .sticky  (err_sticky)
  );

endmodule

// File: rtl/rxaddr_policy_chk.sv
module rxaddr_policy_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_byte,
  input logic              rx_last,
  input logic              err_bre,
  input logic              err_sbpe,
  input logic              err_lbpe,
  input logic              cfg_bre_stop,
  input logic [2:0]        sticky_clr,
  input logic              accept,
  input logic              ack_en,
  input logic              errbit_req,
  input logic              rx_stop,
  input logic [2:0]        err_sticky
);

  // Next strobed byte is a header (observer state).
  logic hdr_next;
  always_ff @(posedge clk) begin
    if (!rst_n)                      hdr_next <= 1'b1;
    else if (err_bre && cfg_bre_stop) hdr_next <= 1'b1;
    else if (rx_valid)                hdr_next <= rx_last;
  end

  assert_ack_needs_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_en |-> accept);

  assert_bcast_no_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && hdr_next && !(err_bre && cfg_bre_stop) && (&(rx_byte | 8'hF0)))
    |=> !ack_en);

  assert_accept_from_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> $past(rx_valid));

  assert_stop_follows_bre_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_bre && cfg_bre_stop) |=> (rx_stop && !accept && !ack_en));

  assert_no_stop_without_bre_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_bre && cfg_bre_stop) |=> !rx_stop);

  assert_quiet_without_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_bre || err_sbpe || err_lbpe) |=> !errbit_req);

  assert_sticky_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ({err_lbpe, err_sbpe, err_bre} != 3'b000)
    |=> ((err_sticky & $past({err_lbpe, err_sbpe, err_bre})) == $past({err_lbpe, err_sbpe, err_bre})));

  assert_sticky_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sticky[1] && !sticky_clr[1]) |=> err_sticky[1]);

endmodule

bind rxaddr_policy rxaddr_policy_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/rxaddr_policy_tb_top.sv
module rxaddr_policy_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 0, rx_last = 0;
  logic [7:0] rx_byte = '0;
  logic err_bre = 0, err_sbpe = 0, err_lbpe = 0;
  logic cfg_full_listen = 0, cfg_bre_stop = 0, cfg_bre_ebit = 0;
  logic cfg_lbpe_ebit = 0, cfg_bcast_quiet = 0;
  logic [14:0] own_mask = '0;
  logic [2:0] sticky_clr = '0;
  logic accept, ack_en, errbit_req, rx_stop;
  logic [2:0] err_sticky;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rxaddr_policy dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_last(rx_last), .err_bre(err_bre), .err_sbpe(err_sbpe), .err_lbpe(err_lbpe),
    .cfg_full_listen(cfg_full_listen), .cfg_bre_stop(cfg_bre_stop),
    .cfg_bre_ebit(cfg_bre_ebit), .cfg_lbpe_ebit(cfg_lbpe_ebit),
    .cfg_bcast_quiet(cfg_bcast_quiet), .own_mask(own_mask), .sticky_clr(sticky_clr),
    .accept(accept), .ack_en(ack_en), .errbit_req(errbit_req), .rx_stop(rx_stop),
    .err_sticky(err_sticky)
  );

  // ---------------- behavioural reference model ----------------
  bit m_in, m_bc, m_own, m_keep, m_on;
  bit x_acc, x_ack, x_err, x_stop;
  bit [2:0] x_sticky;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_in = 0; m_bc = 0; m_own = 0; m_keep = 0; m_on = 0;
      x_acc = 0; x_ack = 0; x_err = 0; x_stop = 0; x_sticky = 0;
    end else begin
      bit bc, stop;
      int d;
      bc   = m_in && m_bc;
      stop = err_bre && cfg_bre_stop;
      x_err = 0;
      if (err_bre && cfg_bre_stop && (bc ? !cfg_bcast_quiet : cfg_bre_ebit)) x_err = 1;
      if (err_lbpe && (bc ? !cfg_bcast_quiet : cfg_lbpe_ebit)) x_err = 1;
      if (err_sbpe && (bc ? (!cfg_bcast_quiet && !cfg_full_listen) : 1'b1)) x_err = 1;
      x_stop = stop;
      x_acc = 0; x_ack = 0;
      if (stop) m_in = 0;
      else if (rx_valid) begin
        if (!m_in) begin
          d = int'(rx_byte[3:0]);
          m_bc   = (d == 15);
          m_own  = (d < 15) && own_mask[d];
          m_keep = m_own || m_bc || cfg_full_listen;
        end
        x_acc = m_keep; x_ack = m_own; m_in = !rx_last;
      end
      for (int i = 0; i < 3; i++) begin
        bit e;
        e = (i == 0) ? err_bre : (i == 1) ? err_sbpe : err_lbpe;
        if (e) x_sticky[i] = 1;
        else if (sticky_clr[i]) x_sticky[i] = 0;
      end
      m_on = 1;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && m_on && !done) begin
      chk("R3 model accept", accept, x_acc);
      chk("R5 model ack_en", ack_en, x_ack);
      chk("R8 model errbit_req", errbit_req, x_err);
      chk("R7 model rx_stop", rx_stop, x_stop);
      for (int i = 0; i < 3; i++) chk("R11 model err_sticky", err_sticky[i], x_sticky[i]);
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input logic v, input logic [7:0] b, input logic l,
                      input logic [2:0] e, input logic [2:0] c);
    rx_valid = v; rx_byte = b; rx_last = l;
    err_lbpe = e[2]; err_sbpe = e[1]; err_bre = e[0];
    sticky_clr = c;
    @(negedge clk);
    rx_valid = 0; rx_last = 0; err_lbpe = 0; err_sbpe = 0; err_bre = 0; sticky_clr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset accept", accept, 0);
    chk("R1 reset ack_en", ack_en, 0);
    chk("R1 reset errbit", errbit_req, 0);
    chk("R1 reset rx_stop", rx_stop, 0);
    chk("R1 reset sticky", |err_sticky, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 post-reset accept", accept, 0);

    // Owned addresses 3 and 9, reduced listen
    own_mask = 15'h0208;
    step(1, 8'h43, 0, 0, 0); chk("R2 hdr dest3 accept", accept, 1); chk("R2 hdr dest3 ack", ack_en, 1);
    step(1, 8'h55, 1, 0, 0); chk("R5 data ack", ack_en, 1);
    step(1, 8'h39, 1, 0, 0); chk("R6 one-byte frame dest9 ack", ack_en, 1);
    step(1, 8'hA9, 1, 0, 0); chk("R2 initiator ignored", accept, 1);
    step(1, 8'h35, 0, 0, 0); chk("R3 foreign hdr rejected", accept, 0);
    step(1, 8'h03, 1, 0, 0); chk("R6 data not decoded as header", accept, 0);
    step(1, 8'h7F, 0, 0, 0); chk("R3 bcast accept", accept, 1); chk("R5 bcast no ack", ack_en, 0);
    step(1, 8'h10, 1, 0, 0); chk("R5 bcast data no ack", ack_en, 0);

    // Full listen
    cfg_full_listen = 1;
    step(1, 8'h35, 0, 0, 0); chk("R4 foreign accept", accept, 1); chk("R4 foreign no ack", ack_en, 0);
    step(1, 8'h22, 1, 0, 0); chk("R4 foreign data no ack", ack_en, 0);
    cfg_full_listen = 0;

    // Error policy in an addressed frame
    step(1, 8'h43, 0, 0, 0);
    cfg_bre_stop = 0; cfg_bre_ebit = 1;
    step(0, 0, 0, 3'b001, 0); chk("R8 bre no stop no ebit", errbit_req, 0); chk("R7 no stop", rx_stop, 0);
    cfg_lbpe_ebit = 0;
    step(0, 0, 0, 3'b100, 0); chk("R8 lbpe disabled", errbit_req, 0);
    cfg_lbpe_ebit = 1;
    step(0, 0, 0, 3'b100, 0); chk("R8 lbpe enabled", errbit_req, 1);
    step(0, 0, 0, 3'b010, 0); chk("R8 sbpe", errbit_req, 1);
    cfg_bre_stop = 1;
    step(0, 0, 0, 3'b001, 0); chk("R8 bre stop+ebit", errbit_req, 1); chk("R7 stop", rx_stop, 1);
    cfg_bre_ebit = 0;
    step(1, 8'h35, 0, 0, 0); chk("R7 next byte is header", accept, 0);
    step(0, 0, 0, 3'b001, 0); chk("R8 bre ebit off", errbit_req, 0);

    // Stop collides with a byte strobe
    step(1, 8'h43, 0, 0, 0);
    step(1, 8'h66, 0, 3'b001, 0); chk("R7 same-cycle byte dropped", accept, 0);
    chk("R7 same-cycle stop", rx_stop, 1);
    step(1, 8'h35, 1, 0, 0); chk("R7 following byte is header", accept, 0);

    // Broadcast, override clear
    cfg_lbpe_ebit = 0;
    step(1, 8'h4F, 0, 0, 0);
    step(0, 0, 0, 3'b100, 0); chk("R9 bcast lbpe", errbit_req, 1);
    step(0, 0, 0, 3'b010, 0); chk("R9 bcast sbpe reduced", errbit_req, 1);
    cfg_full_listen = 1;
    step(0, 0, 0, 3'b010, 0); chk("R9 bcast sbpe full listen", errbit_req, 0);
    cfg_full_listen = 0;
    step(0, 0, 0, 3'b001, 0); chk("R9 bcast bre", errbit_req, 1);

    // Broadcast, override set
    cfg_bcast_quiet = 1;
    step(1, 8'h2F, 0, 0, 0);
    step(0, 0, 0, 3'b110, 0); chk("R10 quiet lbpe+sbpe", errbit_req, 0);
    step(0, 0, 0, 3'b001, 0); chk("R10 quiet bre", errbit_req, 0); chk("R10 quiet still stops", rx_stop, 1);
    cfg_bcast_quiet = 0;

    // Context window
    step(1, 8'h4F, 0, 3'b100, 0); chk("R12 error in header cycle", errbit_req, 0);
    step(1, 8'h01, 1, 3'b100, 0); chk("R12 error in last-byte cycle", errbit_req, 1);
    step(0, 0, 0, 3'b100, 0); chk("R12 error after frame", errbit_req, 0);

    // Sticky flags
    step(0, 0, 0, 0, 3'b111); chk("R11 all cleared", |err_sticky, 0);
    step(0, 0, 0, 3'b010, 0); chk("R11 sbpe set", err_sticky[1], 1);
    step(0, 0, 0, 3'b010, 3'b010); chk("R11 set beats clear", err_sticky[1], 1);
    step(0, 0, 0, 0, 3'b001); chk("R11 other bit clear no effect", err_sticky[1], 1);
    step(0, 0, 0, 0, 3'b010); chk("R11 clear", err_sticky[1], 0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule